// File: doc/BRIEF.md
# I2S Audio Capture Engine

This block takes a three-wire serial audio stream (bit clock, word select and serial data) from an external converter and turns it into 32-bit words for a downstream memory writer. The three pins arrive asynchronously. Each passes through a two-flop synchroniser, and the rising edges of the bit clock are found in the system clock domain. The system clock must run at least four times faster than the bit clock.

A control word selects the capture format: mono or stereo, with 32-bit or 16-bit samples. It also selects standard or one-clock-early data alignment, optional inversion of each sample's most significant bit, and a raw mode. In raw mode the word-select level and the data bit are recorded as one byte per bit clock. Finished words leave on a valid/ready stream. Each word carries a tag naming one of two ping-pong buffers of programmable length.

Each buffer has a full flag that software clears by writing a 1 to it. A word that completes while the previous one is still waiting on the stream is an overrun. An interrupt line combines the two full flags and the overrun flag, each through its own enable. A soft reset started through the control word clears the engine over a fixed number of cycles. It shows as busy while it runs.

Top module: `i2s_capture_core`

## Requirements
- R1: With the enable bit (control bit 0) at 0 the engine produces no words. With it at 1, samples are captured and sent out on the stream.
- R2: Format bits 2:1 = 01 is stereo at 32 bits. Each left sample (word select 0) and then each right sample (word select 1) is delivered as its own word, in stream order.
- R3: Format 00 is mono at 32 bits. Only samples taken while word select is 0 are delivered. Right-channel samples are dropped.
- R4: Format 11 is stereo at 16 bits and format 10 is mono at 16 bits. Two 16-bit samples are packed into one word, with the earlier sample in bits 31:16 and the later one in bits 15:0.
- R5: With control bit 4 at 0 (standard), the first data bit of a sample is taken on the bit-clock rise after the one where the word-select change is seen. The bit taken on that change edge is the last bit of the previous sample. With bit 4 at 1 (early), the first bit is taken on the change edge itself.
- R6: With control bit 3 at 1, the most significant bit of every sample is inverted: bit 31 in 32-bit formats, and bits 31 and 15 in 16-bit formats. With bit 3 at 0, samples pass unchanged.
- R7: Only the first 32 bits (16 in 16-bit formats) after a word-select change are kept, and later bits are ignored. A sample cut short by an early word-select change is left-aligned and padded with zeros.
- R8: With control bit 5 at 1 (raw), each bit-clock rise yields one byte: word select in bit 1, the data bit in bit 0, zeros above. Four bytes form one word, the first byte in bits 31:24.
- R9: Delivered words are tagged with the current buffer (0 or 1). After the programmed number of words (length register, cfg_sel = 1; 0 acts as 1) has been accepted, that buffer's full flag sets and the tag switches to the other buffer.
- R10: A full flag clears when its flag_clr bit is pulsed (bit 0 for buffer 0, bit 1 for buffer 1). The interrupt is high when a full flag and its enable are both 1. The enables are control bit 6 for buffer 0 and bit 7 for buffer 1.
- R11: A word that completes while the previous word is still unaccepted is discarded. The held word stays unchanged, and the overrun flag sets. The overrun flag is cleared by flag_clr bit 2 and drives the interrupt when control bit 8 is 1.
- R12: Writing the control word with bit 31 at 1 holds busy high for RST_CYCLES cycles. This clears the control fields, the stream, the flags and the buffer position, but keeps the length. Configuration writes made while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock, asynchronous |
| ws_i | input | 1 | Word select, asynchronous |
| sd_i | input | 1 | Serial data, asynchronous |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = buffer length |
| cfg_wdata | input | 32 | Configuration write data |
| flag_clr | input | 3 | Write-one-to-clear pulses for the full flags and the overrun flag |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream word accepted |
| out_data | output | 32 | Stream word |
| out_buf | output | 1 | Buffer tag of the stream word |
| full_o | output | 2 | Buffer full flags |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Soft reset in progress |

## Verification
A wrong bit counter or word-select tracker shows up in the very next delivered word. The symptom is a shifted, truncated or wrongly zero-padded sample, or a sample from the wrong channel. The scoreboard catches it one serial sample after the fault. A wrong pack phase in 16-bit or raw mode swaps halves or bytes inside the first packed word. A wrong buffer counter shows as a wrong tag on the word where the switch should have happened, and as a full flag rising one word early or late. A lost stall hold shows as a changed or missing held word after an overrun.

// File: rtl/i2s_cap_pkg.sv
package i2s_cap_pkg;

    // Control fields, packed so that bit 0 is the enable and bit 8 the overrun interrupt enable
    typedef struct packed {
        logic       ien_ovr;
        logic       ien_b1;
        logic       ien_b0;
        logic       raw;
        logic       early;
        logic       sign_inv;
        logic [1:0] fmt;
        logic       en;
    } cap_ctl_t;

    localparam int CTL_W   = 9;
    localparam int RST_BIT = 31;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int CNT_W   = $clog2(WORD_W + 1);

endpackage

// File: rtl/i2s_pin_sync.sv
module i2s_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic sck_rise,
    output logic ws_s,
    output logic sd_s
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] ws;
        logic [STAGES-1:0] sd;
        logic              sck_prev;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.sck      = {s_q.sck[STAGES-2:0], sck_i};
        s_d.ws       = {s_q.ws[STAGES-2:0],  ws_i};
        s_d.sd       = {s_q.sd[STAGES-2:0],  sd_i};
        s_d.sck_prev = s_q.sck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck_rise = s_q.sck[STAGES-1] & ~s_q.sck_prev;
    assign ws_s     = s_q.ws[STAGES-1];
    assign sd_s     = s_q.sd[STAGES-1];

endmodule

// File: rtl/i2s_deser.sv
module i2s_deser
    import i2s_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [1:0]        fmt,
    input  logic              sign_inv,
    input  logic              early,
    input  logic              raw,
    input  logic              bit_stb,
    input  logic              ws,
    input  logic              sd,
    output logic              word_stb,
    output logic [WORD_W-1:0] word_data
);

    typedef struct packed {
        logic              ws_prev;
        logic              primed;
        logic              have;
        logic              chan;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic              half;
        logic [HALF_W-1:0] hold;
        logic [1:0]        rawcnt;
        logic [WORD_W-1:0] word;
        logic              stb;
    } deser_st_t;

    deser_st_t ds_d, ds_q;

    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] aligned;
    logic [WORD_W-1:0] samp;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  wbits;
    logic              chg;

    always_comb begin
        ds_d     = ds_q;
        ds_d.stb = 1'b0;
        sh       = ds_q.shreg;
        cnt      = ds_q.cnt;
        wbits    = fmt[1] ? CNT_W'(HALF_W) : CNT_W'(WORD_W);
        chg      = 1'b0;
        aligned  = '0;
        samp     = '0;
        if (clr || !en) begin
            ds_d = '0;
        end else if (bit_stb) begin
            if (raw) begin
                ds_d.shreg  = {ds_q.shreg[WORD_W-9:0], 6'b0, ws, sd};
                ds_d.rawcnt = ds_q.rawcnt + 2'd1;
                if (ds_q.rawcnt == 2'd3) begin
                    ds_d.word = {ds_q.shreg[WORD_W-9:0], 6'b0, ws, sd};
                    ds_d.stb  = 1'b1;
                end
            end else begin
                chg          = ds_q.primed && (ws != ds_q.ws_prev);
                ds_d.ws_prev = ws;
                ds_d.primed  = 1'b1;
                // bit belongs to the running sample unless early timing hands it to the next one
                if (ds_q.have && (cnt < wbits) && !(chg && early)) begin
                    sh  = {sh[WORD_W-2:0], sd};
                    cnt = cnt + CNT_W'(1);
                end
                if (chg) begin
                    if (ds_q.have) begin
                        aligned = sh << (wbits - cnt);
                        samp    = aligned;
                        if (sign_inv) samp = aligned ^ (WORD_W'(1) << (wbits - CNT_W'(1)));
                        if (fmt[0] || !ds_q.chan) begin
                            if (!fmt[1]) begin
                                ds_d.word = samp;
                                ds_d.stb  = 1'b1;
                            end else if (!ds_q.half) begin
                                ds_d.hold = samp[HALF_W-1:0];
                                ds_d.half = 1'b1;
                            end else begin
                                ds_d.word = {ds_q.hold, samp[HALF_W-1:0]};
                                ds_d.stb  = 1'b1;
                                ds_d.half = 1'b0;
                            end
                        end
                    end
                    ds_d.have = 1'b1;
                    ds_d.chan = ws;
                    if (early) begin
                        sh  = {{(WORD_W-1){1'b0}}, sd};
                        cnt = CNT_W'(1);
                    end else begin
                        sh  = '0;
                        cnt = '0;
                    end
                end
                ds_d.shreg = sh;
                ds_d.cnt   = cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ds_q <= '0;
        else        ds_q <= ds_d;
    end

    assign word_stb  = ds_q.stb;
    assign word_data = ds_q.word;

    // R1: a disabled engine emits nothing on the following cycle
    a_r1_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !word_stb);

    // R7: the bit counter never runs past one full word
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ds_q.cnt <= CNT_W'(WORD_W));

endmodule

// File: rtl/i2s_pingpong.sv
module i2s_pingpong
    import i2s_cap_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [LEN_W-1:0]  len,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] word_data,
    input  logic              out_ready,
    input  logic [2:0]        flag_clr,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_buf,
    output logic [1:0]        full,
    output logic              ovr
);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic              sel;
        logic [LEN_W-1:0]  cnt;
        logic [1:0]        full;
        logic              ovr;
    } pp_st_t;

    pp_st_t pp_d, pp_q;
    logic   hs;

    always_comb begin
        pp_d      = pp_q;
        hs        = pp_q.valid && out_ready;
        pp_d.full = pp_q.full & ~flag_clr[1:0];
        pp_d.ovr  = pp_q.ovr & ~flag_clr[2];
        if (hs) begin
            pp_d.valid = 1'b0;
            if (({1'b0, pp_q.cnt} + (LEN_W+1)'(1)) >= {1'b0, len}) begin
                pp_d.cnt            = '0;
                pp_d.full[pp_q.sel] = 1'b1;
                pp_d.sel            = ~pp_q.sel;
            end else begin
                pp_d.cnt = pp_q.cnt + LEN_W'(1);
            end
        end
        if (word_stb) begin
            if (!pp_q.valid || hs) begin
                pp_d.valid = 1'b1;
                pp_d.data  = word_data;
            end else begin
                pp_d.ovr = 1'b1;
            end
        end
        if (clr) pp_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assign out_valid = pp_q.valid;
    assign out_data  = pp_q.data;
    assign out_buf   = pp_q.sel;
    assign full      = pp_q.full;
    assign ovr       = pp_q.ovr;

    // R11: a stalled word and its tag are held unchanged
    a_r11_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n || clr)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_buf));

    // R9: leaving a buffer always leaves its full flag raised
    a_r9_flag_on_switch: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (out_buf != $past(out_buf)) |-> full[$past(out_buf)]);

endmodule

// File: rtl/i2s_capture_core.sv
module i2s_capture_core
    import i2s_cap_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int RST_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_i,
    input  logic        ws_i,
    input  logic        sd_i,
    input  logic        cfg_wr,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [2:0]  flag_clr,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_buf,
    output logic [1:0]  full_o,
    output logic        ovr_o,
    output logic        irq_o,
    output logic        busy_o
);

    localparam int RC_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        cap_ctl_t         ctl;
        logic [LEN_W-1:0] len;
        logic [RC_W-1:0]  rcnt;
    } top_st_t;

    top_st_t t_d, t_q;
    logic    busy;
    logic    unused_cfg;

    assign unused_cfg = ^cfg_wdata[RST_BIT-1:CTL_W];

    always_comb begin
        t_d  = t_q;
        busy = (t_q.rcnt != '0);
        if (busy) begin
            t_d.rcnt = t_q.rcnt - RC_W'(1);
        end else if (cfg_wr) begin
            if (!cfg_sel) begin
                if (cfg_wdata[RST_BIT]) begin
                    t_d.ctl  = '0;
                    t_d.rcnt = RC_W'(RST_CYCLES);
                end else begin
                    t_d.ctl = cap_ctl_t'(cfg_wdata[CTL_W-1:0]);
                end
            end else begin
                t_d.len = cfg_wdata[LEN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    logic              bit_stb, ws_s, sd_s;
    logic              word_stb;
    logic [WORD_W-1:0] word_data;

    i2s_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .ws_i     (ws_i),
        .sd_i     (sd_i),
        .sck_rise (bit_stb),
        .ws_s     (ws_s),
        .sd_s     (sd_s)
    );

    i2s_deser u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (busy),
        .en        (t_q.ctl.en),
        .fmt       (t_q.ctl.fmt),
        .sign_inv  (t_q.ctl.sign_inv),
        .early     (t_q.ctl.early),
        .raw       (t_q.ctl.raw),
        .bit_stb   (bit_stb),
        .ws        (ws_s),
        .sd        (sd_s),
        .word_stb  (word_stb),
        .word_data (word_data)
    );

    i2s_pingpong #(.LEN_W(LEN_W)) u_pp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (busy),
        .len       (t_q.len),
        .word_stb  (word_stb),
        .word_data (word_data),
        .out_ready (out_ready),
        .flag_clr  (flag_clr),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_buf   (out_buf),
        .full      (full_o),
        .ovr       (ovr_o)
    );

    assign busy_o = busy;
    assign irq_o  = (full_o[0] & t_q.ctl.ien_b0) | (full_o[1] & t_q.ctl.ien_b1)
                  | (ovr_o & t_q.ctl.ien_ovr);

    // R12: the stream is empty from the cycle after a busy cycle
    a_r12_idle_during_reset: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !out_valid && (full_o == 2'b00) && !ovr_o);

    // R10: an interrupt always has a raised flag behind it
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (full_o != 2'b00) || ovr_o);

endmodule

// File: tb/test_i2s_capture_core.sv
module test_i2s_capture_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  flag_clr = '0;
    logic        out_valid, out_ready = 1'b1, out_buf;
    logic [31:0] out_data;
    logic [1:0]  full_o;
    logic        ovr_o, irq_o, busy_o;

    localparam logic [31:0] C_EN = 32'h1, C_SIGN = 32'h8, C_EARLY = 32'h10, C_RAW = 32'h20;
    localparam logic [31:0] C_IB0 = 32'h40, C_IB1 = 32'h80, C_IOV = 32'h100;
    localparam logic [31:0] F_M32 = 32'h0, F_S32 = 32'h2, F_M16 = 32'h4, F_S16 = 32'h6;

    always #4 clk = ~clk;

    i2s_capture_core i_i2s_capture_core (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .flag_clr(flag_clr),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_buf(out_buf),
        .full_o(full_o), .ovr_o(ovr_o), .irq_o(irq_o), .busy_o(busy_o)
    );

    int n_chk = 0, n_fail = 0;
    logic [31:0] q_data[$];
    logic        q_tag[$];
    string       q_req[$];
    int          lenv = 0, exp_cnt = 0;
    logic        exp_sel = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] d, input string req);
        q_data.push_back(d);
        q_tag.push_back(exp_sel);
        q_req.push_back(req);
        exp_cnt++;
        if (exp_cnt >= ((lenv == 0) ? 1 : lenv)) begin
            exp_cnt = 0;
            exp_sel = ~exp_sel;
        end
    endtask

    // monitor: compare each accepted word against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (q_data.size() == 0) begin
                chk(1'b0, "R1 unexpected word", out_data, 32'h0);
            end else begin
                logic [31:0] ed;
                logic        et;
                string       er;
                ed = q_data.pop_front();
                et = q_tag.pop_front();
                er = q_req.pop_front();
                chk(out_data == ed, er, out_data, ed);
                chk(out_buf == et, {er, " R9 tag"}, 32'(out_buf), 32'(et));
            end
        end
    end

    function automatic logic [31:0] xs(input logic [63:0] d, input int n, input int w, input bit inv);
        logic [63:0] v;
        if (n >= w) v = d >> (n - w);
        else        v = d << (w - n);
        v = v & ((64'd1 << w) - 64'd1);
        if (inv) v[w-1] = ~v[w-1];
        return v[31:0];
    endfunction

    task automatic cfg_write(input logic sel, input logic [31:0] v);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic setup(input logic [31:0] v);
        cfg_write(1'b0, 32'h0);
        cfg_write(1'b0, v);
    endtask

    task automatic edge_bit(input logic w, input logic s);
        @(posedge clk); #1;
        sck_i = 1'b0; ws_i = w; sd_i = s;
        repeat (4) @(posedge clk);
        #1 sck_i = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    task automatic send_slot(input logic c, input logic [63:0] d, input int n, input bit early);
        for (int i = n - 1; i >= 0; i--)
            edge_bit((!early && i == 0) ? ~c : c, d[i]);
    endtask

    task automatic prelude(input bit early);
        edge_bit(1'b1, 1'b0);
        edge_bit(1'b1, 1'b0);
        if (!early) edge_bit(1'b0, 1'b0);
    endtask

    task automatic settle(input string req);
        repeat (40) @(posedge clk);
        #1;
        chk(q_data.size() == 0, req, 32'(q_data.size()), 32'h0);
    endtask

    task automatic pulse_clr(input logic [2:0] v);
        @(posedge clk); #1 flag_clr = v;
        @(posedge clk); #1 flag_clr = '0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] a, b, c2, d2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(out_valid == 1'b0, "R12 reset valid", 32'(out_valid), 32'h0);
        chk(full_o == 2'b00 && !ovr_o, "R12 reset flags", {29'b0, ovr_o, full_o}, 32'h0);
        chk(irq_o == 1'b0 && busy_o == 1'b0, "R12 reset irq/busy", {30'b0, irq_o, busy_o}, 32'h0);

        // R1: disabled engine delivers nothing
        setup(F_S32);
        prelude(0); send_slot(0, 64'h1234_5678, 32, 0); send_slot(1, 64'h9abc_def0, 32, 0);
        settle("R1 disabled drain");
        chk(out_valid == 1'b0, "R1 no word when disabled", 32'(out_valid), 32'h0);

        // R2: stereo 32-bit standard timing
        a = 64'hA5C3_0F1E; b = 64'h1357_9BDF;
        setup(C_EN | F_S32);
        push(xs(a, 32, 32, 0), "R2 left"); push(xs(b, 32, 32, 0), "R2 right");
        prelude(0); send_slot(0, a, 32, 0); send_slot(1, b, 32, 0);
        settle("R2 drain");

        // R3: mono 32-bit drops the right channel
        a = 64'h8000_0001; b = 64'hFFFF_0000;
        setup(C_EN | F_M32);
        push(xs(a, 32, 32, 0), "R3 left only");
        prelude(0); send_slot(0, a, 32, 0); send_slot(1, b, 32, 0);
        settle("R3 drain");

        // R4: stereo 16-bit packing, earlier sample on top
        a = 64'hBEEF; b = 64'h0123;
        setup(C_EN | F_S16);
        push({xs(a, 16, 16, 0)[15:0], xs(b, 16, 16, 0)[15:0]}, "R4 stereo16");
        prelude(0); send_slot(0, a, 16, 0); send_slot(1, b, 16, 0);
        settle("R4 stereo16 drain");

        // R4: mono 16-bit packs two left samples
        a = 64'h4C1D; b = 64'h7777; c2 = 64'h2E9A; d2 = 64'h1111;
        setup(C_EN | F_M16);
        push({xs(a, 16, 16, 0)[15:0], xs(c2, 16, 16, 0)[15:0]}, "R4 mono16");
        prelude(0); send_slot(0, a, 16, 0); send_slot(1, b, 16, 0);
        send_slot(0, c2, 16, 0); send_slot(1, d2, 16, 0);
        settle("R4 mono16 drain");

        // R5: early alignment, stereo 32
        a = 64'h6B2F_90D4; b = 64'hC0DE_5A17;
        setup(C_EN | F_S32 | C_EARLY);
        push(xs(a, 32, 32, 0), "R5 early left"); push(xs(b, 32, 32, 0), "R5 early right");
        prelude(1); send_slot(0, a, 32, 1); send_slot(1, b, 32, 1); edge_bit(1'b0, 1'b0);
        settle("R5 drain");

        // R6: sign inversion in 16-bit and 32-bit formats
        a = 64'h8123; b = 64'h7F00;
        setup(C_EN | F_S16 | C_SIGN);
        push({xs(a, 16, 16, 1)[15:0], xs(b, 16, 16, 1)[15:0]}, "R6 sign16");
        prelude(0); send_slot(0, a, 16, 0); send_slot(1, b, 16, 0);
        settle("R6 sign16 drain");
        a = 64'h0000_00FF;
        setup(C_EN | F_M32 | C_SIGN);
        push(xs(a, 32, 32, 1), "R6 sign32");
        prelude(0); send_slot(0, a, 32, 0); send_slot(1, 64'h0, 32, 0);
        settle("R6 sign32 drain");

        // R7: short slot padded, long slot truncated
        a = 64'h000A_BCDE; b = 64'hF_1234_5678;
        setup(C_EN | F_S32);
        push(xs(a, 20, 32, 0), "R7 short pad"); push(xs(b, 36, 32, 0), "R7 long cut");
        prelude(0); send_slot(0, a, 20, 0); send_slot(1, b, 36, 0);
        settle("R7 drain");

        // R8: raw mode, byte = {6'b0, ws, sd}, first byte on top
        setup(C_EN | C_RAW);
        begin
            logic [7:0] pat;
            logic [31:0] w0, w1;
            pat = 8'b1011_0010;
            w0 = '0; w1 = '0;
            for (int i = 0; i < 8; i++) begin
                logic [7:0] by;
                by = {6'b0, (i % 3 == 0), pat[i]};
                if (i < 4) w0 = {w0[23:0], by};
                else       w1 = {w1[23:0], by};
            end
            push(w0, "R8 raw word0"); push(w1, "R8 raw word1");
            for (int i = 0; i < 8; i++) edge_bit((i % 3 == 0), pat[i]);
        end
        settle("R8 drain");

        // R9/R10: ping-pong with length 2 after a soft reset
        cfg_write(1'b0, 32'h8000_0000);
        repeat (10) @(posedge clk);
        exp_sel = 1'b0; exp_cnt = 0; lenv = 2;
        cfg_write(1'b1, 32'd2);
        setup(C_EN | F_S32 | C_IB0 | C_IB1);
        a = 64'h1111_2222; b = 64'h3333_4444; c2 = 64'h5555_6666; d2 = 64'h7777_8888;
        push(a[31:0], "R9 b0 w0"); push(b[31:0], "R9 b0 w1");
        push(c2[31:0], "R9 b1 w0"); push(d2[31:0], "R9 b1 w1");
        prelude(0); send_slot(0, a, 32, 0); send_slot(1, b, 32, 0);
        send_slot(0, c2, 32, 0); send_slot(1, d2, 32, 0);
        settle("R9 drain");
        chk(full_o == 2'b11, "R9 both full", 32'(full_o), 32'h3);
        chk(irq_o == 1'b1, "R10 irq with enables", 32'(irq_o), 32'h1);
        cfg_write(1'b0, C_EN | F_S32);
        #1;
        chk(irq_o == 1'b0, "R10 irq masked", 32'(irq_o), 32'h0);
        cfg_write(1'b0, C_EN | F_S32 | C_IB0 | C_IB1);
        pulse_clr(3'b001);
        chk(full_o == 2'b10, "R10 clear buf0", 32'(full_o), 32'h2);
        chk(irq_o == 1'b1, "R10 irq from buf1", 32'(irq_o), 32'h1);
        pulse_clr(3'b010);
        chk(full_o == 2'b00 && !irq_o, "R10 clear buf1", {30'b0, irq_o, full_o[0] | full_o[1]}, 32'h0);

        // R9: length 0 acts as 1
        lenv = 0;
        cfg_write(1'b1, 32'd0);
        setup(C_EN | F_S32);
        a = 64'hAAAA_0001; b = 64'hBBBB_0002;
        push(a[31:0], "R9 len0 first"); push(b[31:0], "R9 len0 second");
        prelude(0); send_slot(0, a, 32, 0); send_slot(1, b, 32, 0);
        settle("R9 len0 drain");
        chk(full_o == 2'b11, "R9 len0 flags", 32'(full_o), 32'h3);
        pulse_clr(3'b011);

        // R11: overrun while stalled
        @(posedge clk); #1 out_ready = 1'b0;
        setup(C_EN | F_M32 | C_IOV);
        a = 64'hDEAD_BEEF; c2 = 64'hFACE_0FF1;
        prelude(0); send_slot(0, a, 32, 0); send_slot(1, 64'h0, 32, 0);
        send_slot(0, c2, 32, 0); send_slot(1, 64'h0, 32, 0);
        repeat (20) @(posedge clk); #1;
        chk(ovr_o == 1'b1, "R11 overrun flag", 32'(ovr_o), 32'h1);
        chk(irq_o == 1'b1, "R11 overrun irq", 32'(irq_o), 32'h1);
        chk(out_valid && out_data == a[31:0], "R11 held word", out_data, a[31:0]);
        push(a[31:0], "R11 first word delivered");
        @(posedge clk); #1 out_ready = 1'b1;
        settle("R11 drain");
        pulse_clr(3'b100);
        chk(!ovr_o && !irq_o, "R11 overrun cleared", {30'b0, ovr_o, irq_o}, 32'h0);

        // R12: soft reset
        chk(full_o != 2'b00, "R12 flag set before reset", 32'(full_o), 32'h1);
        cfg_write(1'b0, 32'h8000_0000);
        chk(busy_o == 1'b1, "R12 busy after write", 32'(busy_o), 32'h1);
        cfg_write(1'b0, C_EN | F_S32);
        repeat (10) @(posedge clk); #1;
        chk(busy_o == 1'b0, "R12 busy ends", 32'(busy_o), 32'h0);
        chk(full_o == 2'b00 && !ovr_o, "R12 flags cleared", {29'b0, ovr_o, full_o}, 32'h0);
        prelude(0); send_slot(0, 64'h1234, 32, 0); send_slot(1, 64'h5678, 32, 0);
        settle("R12 drain");
        chk(out_valid == 1'b0, "R12 write during busy ignored", 32'(out_valid), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule